// File: doc/BRIEF.md
# Fractional-Rate Realtime Counter

This block keeps a 64-bit free-running count whose average rate is a programmable fraction of the clock that drives it. Software writes a ratio numerator and a ratio denominator. On every clock the block adds the numerator to a phase accumulator. Each time the accumulator reaches the denominator, the denominator is taken off and the count steps by one. The count rate is therefore the clock rate times numerator over denominator. A fixed target rate, for example 6.144 MHz, can be held from many different input clocks: 64/125 at 12 MHz, 768/1625 at 13 MHz, 8/25 at 19.2 MHz, 192/625 at 20 MHz, 384/1625 at 26 MHz, 256/1125 at 27 MHz, 4/25 at 38.4 MHz. When the slow reference is made by dividing the clock by 610, the ratio is 75/244.

Software reaches the block through a simple word-wide register port. It can read the count as two words, and a snapshot taken on the low-word read keeps the pair consistent. The full count is also given on a port for hardware users.

Top module: `frac_rt_counter`

## Requirements
- R1: While `rst` is high and after it, the count equals the parameter `RST_COUNT`, `rdata` is zero, and the numerator and denominator registers hold `RST_NUM` and `RST_DEN`.
- R2: With 0 < numerator < denominator, over N clocks that follow a ratio write the count grows by exactly floor(N x numerator / denominator).
- R3: The count never advances by more than one in a single clock.
- R4: A ratio field of zero in either the numerator or the denominator freezes the count.
- R5: When numerator >= denominator and both are non-zero, the count advances on every clock.
- R6: A write to the numerator (offset 0x10) or the denominator (offset 0x14) resets the phase accumulator to zero, and the count does not advance in that clock.
- R7: The ratio field of each register is bits [11:0]. The upper 20 bits are stored as written and read back, and they have no effect on the rate.
- R8: A read that `rd_en` samples at a clock edge updates `rdata` at that edge, and `rdata` holds until the next read. Offset 0x00 returns count bits [31:0] as they were before that edge and captures count bits [63:32] into a snapshot. Offset 0x04 returns that snapshot.
- R9: The count wraps from all-ones to zero, modulo 2^64.
- R10: Reads of offsets that have no register return zero. Writes to those offsets, and to 0x00 or 0x04, change no state and do not stall the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock; also the base of the count rate |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W (8) | Byte offset of the register |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Registered read data |
| count | output | 2*DATA_W (64) | Current count value |

## Verification
The bench builds the block with its default 32-bit words and 12-bit ratio fields, so the real clock ratios from 64/125 to 75/244 run as written. It sets `RST_COUNT` to 32 counts below the 64-bit wrap. This puts the carry out of the low word, the full wrap to zero and the snapshot keeping the old high word within a few dozen clocks. Runs of several thousand clocks per ratio compare the exact floor of the expected count growth. This makes an accumulator that is off by one, or a subtraction that is missing, show up as a count difference.

// File: rtl/frc_pkg.sv
package frc_pkg;

  localparam int unsigned OFS_CNT_LO = 32'h00;
  localparam int unsigned OFS_CNT_HI = 32'h04;
  localparam int unsigned OFS_NUM    = 32'h10;
  localparam int unsigned OFS_DEN    = 32'h14;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CNT_LO,
    SEL_CNT_HI,
    SEL_NUM,
    SEL_DEN
  } reg_sel_e;

  function automatic reg_sel_e decode_sel(input logic [31:0] ofs);
    reg_sel_e s;
    case (ofs)
      OFS_CNT_LO: s = SEL_CNT_LO;
      OFS_CNT_HI: s = SEL_CNT_HI;
      OFS_NUM:    s = SEL_NUM;
      OFS_DEN:    s = SEL_DEN;
      default:    s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/frc_ratio_regs.sv
module frc_ratio_regs
  import frc_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned RATIO_W = 12,
  parameter int unsigned RST_NUM = 64,
  parameter int unsigned RST_DEN = 125
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] num_word,
  output logic [DATA_W-1:0] den_word,
  output logic              phase_clr
);

  reg_sel_e sel;
  logic     hit_num;
  logic     hit_den;

  always_comb begin
    sel     = decode_sel(32'(addr));
    hit_num = wr_en && (sel == SEL_NUM);
    hit_den = wr_en && (sel == SEL_DEN);
  end

  assign phase_clr = hit_num || hit_den;

  always_ff @(posedge clk) begin
    if (rst) begin
      num_word <= DATA_W'(RST_NUM);
      den_word <= DATA_W'(RST_DEN);
    end else begin
      if (hit_num) num_word <= wdata;
      if (hit_den) den_word <= wdata;
    end
  end

  // R7: a write stores the whole word, upper bits included
  a_r7_word_kept: assert property (@(posedge clk) disable iff (rst)
    hit_num |=> num_word == $past(wdata));

endmodule

// File: rtl/frc_phase_acc.sv
module frc_phase_acc #(
  parameter int unsigned RATIO_W = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [RATIO_W-1:0] num,
  input  logic [RATIO_W-1:0] den,
  input  logic               clr,
  output logic               tick
);

  localparam int unsigned ACC_W = RATIO_W + 1;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] sum;
  logic             halted;
  logic             full_rate;
  logic             reached;

  always_comb begin
    sum       = acc_q + {1'b0, num};
    halted    = (num == '0) || (den == '0);
    full_rate = (num >= den);
    reached   = (sum >= {1'b0, den});
    tick      = !clr && !halted && (full_rate || reached);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
    end else if (clr || halted || full_rate) begin
      acc_q <= '0;
    end else if (reached) begin
      acc_q <= sum - {1'b0, den};
    end else begin
      acc_q <= sum;
    end
  end

  // R6: a ratio write leaves a clean phase
  a_r6_phase_clear: assert property (@(posedge clk) disable iff (rst)
    clr |=> acc_q == '0);

  // R2: the residue stays below the denominator in fractional operation
  a_r2_acc_bound: assert property (@(posedge clk) disable iff (rst)
    (!halted && !full_rate) |-> acc_q < {1'b0, den});

endmodule

// File: rtl/frc_count_reg.sv
module frc_count_reg #(
  parameter int unsigned               CNT_W     = 64,
  parameter logic [CNT_W-1:0]          RST_COUNT = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  output logic [CNT_W-1:0] value
);

  always_ff @(posedge clk) begin
    if (rst) value <= RST_COUNT;
    else if (step) value <= value + CNT_W'(1);
  end

  // R3: at most one step per clock, R9: wraps naturally
  a_r3_single_step: assert property (@(posedge clk) disable iff (rst)
    (value == $past(value)) || (value == $past(value) + CNT_W'(1)));

endmodule

// File: rtl/frc_read_port.sv
module frc_read_port
  import frc_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [2*DATA_W-1:0] count,
  input  logic [DATA_W-1:0]   num_word,
  input  logic [DATA_W-1:0]   den_word,
  output logic [DATA_W-1:0]   rdata
);

  reg_sel_e          sel;
  logic [DATA_W-1:0] hi_snap;

  assign sel = decode_sel(32'(addr));

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata   <= '0;
      hi_snap <= '0;
    end else if (rd_en) begin
      case (sel)
        SEL_CNT_LO: begin
          rdata   <= count[DATA_W-1:0];
          hi_snap <= count[2*DATA_W-1:DATA_W];
        end
        SEL_CNT_HI: rdata <= hi_snap;
        SEL_NUM:    rdata <= num_word;
        SEL_DEN:    rdata <= den_word;
        default:    rdata <= '0;
      endcase
    end
  end

  // R8: the low-word read captures the matching high word
  a_r8_snapshot: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel == SEL_CNT_LO) |=> hi_snap == $past(count[2*DATA_W-1:DATA_W]));

  // R8: data only moves on a read
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));

endmodule

// File: rtl/frac_rt_counter.sv
module frac_rt_counter #(
  parameter int unsigned         DATA_W    = 32,
  parameter int unsigned         ADDR_W    = 8,
  parameter int unsigned         RATIO_W   = 12,
  parameter int unsigned         RST_NUM   = 64,
  parameter int unsigned         RST_DEN   = 125,
  parameter logic [2*DATA_W-1:0] RST_COUNT = '0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  output logic [2*DATA_W-1:0] count
);

  localparam int unsigned CNT_W = 2 * DATA_W;

  logic [DATA_W-1:0] num_word;
  logic [DATA_W-1:0] den_word;
  logic              phase_clr;
  logic              tick;

  frc_ratio_regs #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .RATIO_W(RATIO_W),
    .RST_NUM(RST_NUM),
    .RST_DEN(RST_DEN)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .num_word (num_word),
    .den_word (den_word),
    .phase_clr(phase_clr)
  );

  frc_phase_acc #(
    .RATIO_W(RATIO_W)
  ) u_acc (
    .clk (clk),
    .rst (rst),
    .num (num_word[RATIO_W-1:0]),
    .den (den_word[RATIO_W-1:0]),
    .clr (phase_clr),
    .tick(tick)
  );

  frc_count_reg #(
    .CNT_W    (CNT_W),
    .RST_COUNT(RST_COUNT)
  ) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .step (tick),
    .value(count)
  );

  frc_read_port #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .addr    (addr),
    .count   (count),
    .num_word(num_word),
    .den_word(den_word),
    .rdata   (rdata)
  );

  logic ratio_zero;
  logic ratio_full;
  assign ratio_zero = (num_word[RATIO_W-1:0] == '0) || (den_word[RATIO_W-1:0] == '0);
  assign ratio_full = (num_word[RATIO_W-1:0] >= den_word[RATIO_W-1:0]);

  // R4: a zero field freezes the count
  a_r4_frozen: assert property (@(posedge clk) disable iff (rst)
    ratio_zero |=> $stable(count));

  // R5: numerator at or above denominator counts every clock
  a_r5_full_rate: assert property (@(posedge clk) disable iff (rst)
    (!ratio_zero && ratio_full && !phase_clr) |=> count == $past(count) + CNT_W'(1));

  // R6: no step in the clock of a ratio write
  a_r6_write_stall: assert property (@(posedge clk) disable iff (rst)
    phase_clr |=> $stable(count));

endmodule

// File: tb/frac_rt_counter_bench.sv
module frac_rt_counter_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] START = 64'hFFFF_FFFF_FFFF_FFE0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [63:0] count;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frac_rt_counter #(
    .RST_NUM  (64),
    .RST_DEN  (125),
    .RST_COUNT(START)
  ) u_frac_rt_counter (
    .clk  (clk),
    .rst  (rst),
    .wr_en(wr_en),
    .rd_en(rd_en),
    .addr (addr),
    .wdata(wdata),
    .rdata(rdata),
    .count(count)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // every task starts and ends at a falling edge
  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] d, output logic [63:0] c_at);
    c_at = count;
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic set_ratio(input logic [31:0] n, input logic [31:0] d);
    wr_reg(8'h10, n);
    wr_reg(8'h14, d);
  endtask

  task automatic t_reset;
    logic [31:0] d; logic [63:0] c;
    repeat (3) @(negedge clk);
    chk("R1 count in reset", count, START);
    chk("R1 rdata in reset", {32'h0, rdata}, 64'h0);
    rst = 1'b0;
    rd_reg(8'h10, d, c);
    chk("R1 numerator reset", {32'h0, d}, 64'd64);
    rd_reg(8'h14, d, c);
    chk("R1 denominator reset", {32'h0, d}, 64'd125);
  endtask

  task automatic t_snapshot_wrap;
    logic [31:0] d; logic [63:0] c, c0, c2;
    rd_reg(8'h00, d, c);
    chk("R8 low word", {32'h0, d}, {32'h0, c[31:0]});
    set_ratio(32'd1, 32'd1);
    c0 = count;
    repeat (40) @(negedge clk);
    chk("R9 wrap modulo 2^64", count, c0 + 64'd40);
    chk("R9 high word after wrap", {32'h0, count[63:32]}, 64'h0);
    chk("R3 one step per clock", count - c0, 64'd40);
    rd_reg(8'h04, d, c2);
    chk("R8 snapshot keeps old high", {32'h0, d}, {32'h0, c[63:32]});
    rd_reg(8'h00, d, c);
    chk("R8 low word after wrap", {32'h0, d}, {32'h0, c[31:0]});
    rd_reg(8'h04, d, c2);
    chk("R8 new snapshot", {32'h0, d}, {32'h0, c[63:32]});
  endtask

  task automatic t_rate(input int unsigned n, input int unsigned d, input int unsigned cyc, input string tag);
    logic [63:0] c0; longint unsigned exp;
    set_ratio(n, d);
    c0 = count;
    repeat (cyc) @(negedge clk);
    if (n == 0 || d == 0) exp = 0;
    else if (n >= d) exp = cyc;
    else exp = (longint'(cyc) * longint'(n)) / longint'(d);
    chk(tag, count - c0, exp);
  endtask

  task automatic t_upper_bits;
    logic [31:0] d; logic [63:0] c;
    logic [63:0] c0;
    wr_reg(8'h10, 32'hABCD_E008);
    wr_reg(8'h14, 32'h1234_5019);
    c0 = count;
    repeat (1000) @(negedge clk);
    chk("R7 rate uses low field only", count - c0, 64'd320);
    rd_reg(8'h10, d, c);
    chk("R7 numerator readback", {32'h0, d}, 64'hABCD_E008);
    rd_reg(8'h14, d, c);
    chk("R7 denominator readback", {32'h0, d}, 64'h1234_5019);
  endtask

  task automatic t_clear;
    logic [63:0] c0;
    set_ratio(32'd3, 32'd4);
    c0 = count;
    @(negedge clk);
    wr_reg(8'h10, 32'd3);
    @(negedge clk);
    chk("R6 write clears phase", count - c0, 64'd0);
    @(negedge clk);
    chk("R6 first step after clear", count - c0, 64'd1);
  endtask

  task automatic t_unmapped;
    logic [31:0] d; logic [63:0] c, c0;
    set_ratio(32'd1, 32'd1);
    rd_reg(8'h08, d, c);
    chk("R10 unmapped read", {32'h0, d}, 64'h0);
    c0 = count;
    wr_reg(8'h00, 32'hFFFF_FFFF);
    chk("R10 count write ignored", count, c0 + 64'd1);
    wr_reg(8'h20, 32'h5);
    rd_reg(8'h10, d, c);
    chk("R10 stray write leaves numerator", {32'h0, d}, 64'd1);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_snapshot_wrap();
    t_rate(64, 125, 5000, "R2 ratio 64/125");
    t_rate(768, 1625, 5000, "R2 ratio 768/1625");
    t_rate(8, 25, 5000, "R2 ratio 8/25");
    t_rate(384, 1625, 5000, "R2 ratio 384/1625");
    t_rate(4, 25, 5000, "R2 ratio 4/25");
    t_rate(75, 244, 5000, "R2 ratio 75/244");
    t_rate(256, 1125, 5000, "R2 ratio 256/1125");
    t_rate(0, 25, 300, "R4 zero numerator");
    t_rate(7, 0, 300, "R4 zero denominator");
    t_rate(30, 30, 100, "R5 equal ratio");
    t_rate(4000, 9, 100, "R5 numerator above denominator R3");
    t_upper_bits();
    t_clear();
    t_unmapped();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule